// File: doc/BRIEF.md
# Calibration Waveform Player

The block replays a stored waveform into a 12-bit calibration DAC. Software fills a sample memory through a small write-only register set (a write pointer, an auto-advancing data port, a prescaler, a divisor and a control word), then starts playback. A sample-rate tick is made from the system clock by a power-of-two prescaler followed by an integer divider. Each tick emits the next stored sample, and the sequence repeats without a gap.

Two storage modes are offered. In the normal mode every 18-bit memory word holds one 12-bit sample, which gives 256 samples. In the packed mode each pair of words holds three samples, which gives 384 samples from the same memory. An enable bit switches the DAC output between the player and the functional sample stream that the DAC carries in normal operation. A reload bit parks the player at its first sample.

Top module: `cal_wave_player`

## Requirements
- R1: While and after rst_ni is low, with no register written, dac_o equals func_sample_i and sample_stb_o is low.
- R2: With control bit 6 (enable) clear, dac_o equals func_sample_i in the same cycle. With it set, dac_o shows the player's sample register.
- R3: While running (enable set, reload clear), sample_stb_o is high for one cycle every 2^P*(D+1) clocks. P is the prescaler (address 1, bits 3:0) and D is the divisor (address 2, bits 7:0).
- R4: In normal mode (control bit 5 clear), the k-th strobe after start presents bits 11:0 of word k mod 256.
- R5: In packed mode (control bit 5 set), group g (0..127) emits in this order: word 2g bits 11:0, word 2g+1 bits 11:0, then {word 2g bits 17:12, word 2g+1 bits 17:12}. After group 127 the sequence wraps to group 0, so one period is 384 samples.
- R6: With control bit 4 (reload) set, no strobe is produced, and dac_o is 2048 if enable is set. Clearing reload with enable set starts playback at sample 0. Stopping and restarting always resumes at sample 0.
- R7: A write to address 3 sets the write pointer to data bits 7:0. A write to address 4 stores data bits 17:0 at the pointer and advances the pointer modulo 256. Address 0 is the control word.
- R8: A prescaler or divisor write made while running leaves the tick interval in progress unchanged. The new period applies from the following tick boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | 18 | Register write data |
| func_sample_i | input | 12 | Functional DAC code used when the player is disabled |
| dac_o | output | 12 | Code to the DAC |
| sample_stb_o | output | 1 | One-cycle pulse when dac_o takes a new played sample |

## Verification
The assertions assume that the register writes are single-cycle strobes and that the prescaler stays within its 4-bit field. They also assume that the sample memory is loaded before playback starts. The stimulus loads every word through the pointer and data ports before any run and changes timing registers only between runs, except in the one directed case that checks deferred period changes. Random data, prescaler and divisor values come from a fixed seed, and the divisor is kept small so that whole wraps fit in a short run.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_PRESC = 3'd1,
    REG_DIV   = 3'd2,
    REG_PTR   = 3'd3,
    REG_DATA  = 3'd4
  } reg_sel_e;

  localparam int CTRL_RLD_BIT = 4;
  localparam int CTRL_ILV_BIT = 5;
  localparam int CTRL_EN_BIT  = 6;
endpackage

// File: rtl/cal_cfg_regs.sv
module cal_cfg_regs
  import cal_pkg::*;
#(
  parameter int WORD_W  = 18,
  parameter int DEPTH   = 256,
  parameter int PRESC_W = 4,
  parameter int DIV_W   = 8,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  output logic               en_o,
  output logic               rld_o,
  output logic               ilv_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic [DIV_W-1:0]   div_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o
);
  logic [AW-1:0] wr_ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      rld_o   <= 1'b0;
      ilv_o   <= 1'b0;
      presc_o <= '0;
      div_o   <= '0;
      wr_ptr  <= '0;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_addr_i))
        REG_CTRL: begin
          rld_o <= wr_data_i[CTRL_RLD_BIT];
          ilv_o <= wr_data_i[CTRL_ILV_BIT];
          en_o  <= wr_data_i[CTRL_EN_BIT];
        end
        REG_PRESC: presc_o <= wr_data_i[PRESC_W-1:0];
        REG_DIV:   div_o   <= wr_data_i[DIV_W-1:0];
        REG_PTR:   wr_ptr  <= wr_data_i[AW-1:0];
        REG_DATA:  wr_ptr  <= wr_ptr + AW'(1);
        default: ;
      endcase
    end
  end

  assign mem_we_o    = wr_en_i && (wr_addr_i == REG_DATA);
  assign mem_addr_o  = wr_ptr;
  assign mem_wdata_o = wr_data_i;

  // R7
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (wr_ptr == $past(wr_ptr) + AW'(1)));
endmodule

// File: rtl/cal_tick_gen.sv
module cal_tick_gen #(
  parameter int PRESC_W = 4,
  parameter int DIV_W   = 8,
  localparam int PRE_CW = (1 << PRESC_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [DIV_W-1:0]   div_i,
  output logic               tick_o
);
  logic [PRE_CW-1:0]  pre_cnt, pre_lim;
  logic [DIV_W-1:0]   div_cnt, div_lat;
  logic [PRESC_W-1:0] presc_lat;
  logic               pre_wrap;

  always_comb pre_lim = {PRE_CW{1'b1}} >> (PRE_CW - int'(presc_lat));
  assign pre_wrap = (pre_cnt == pre_lim);
  assign tick_o   = run_i && pre_wrap && (div_cnt == div_lat);

  // timing values are sampled only while idle or on a tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt   <= '0;
      div_cnt   <= '0;
      presc_lat <= '0;
      div_lat   <= '0;
    end else if (!run_i) begin
      pre_cnt   <= '0;
      div_cnt   <= '0;
      presc_lat <= presc_i;
      div_lat   <= div_i;
    end else if (pre_wrap) begin
      pre_cnt <= '0;
      if (div_cnt == div_lat) begin
        div_cnt   <= '0;
        presc_lat <= presc_i;
        div_lat   <= div_i;
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end else begin
      pre_cnt <= pre_cnt + PRE_CW'(1);
    end
  end

  // R3
  pre_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cnt <= pre_lim);
  // R3
  div_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_cnt <= div_lat);
  // R8
  period_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o) |=> ($stable(div_lat) && $stable(presc_lat)));
endmodule

// File: rtl/cal_sample_mem.sv
module cal_sample_mem #(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [WORD_W-1:0] rdata_a_o,
  output logic [WORD_W-1:0] rdata_b_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];
endmodule

// File: rtl/cal_play_seq.sv
module cal_play_seq #(
  parameter int SMP_W  = 12,
  parameter int WORD_W = 18,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int GRP   = DEPTH / 2,
  localparam logic [SMP_W-1:0] MID = SMP_W'(1) << (SMP_W - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              ilv_i,
  output logic [AW-1:0]     raddr_a_o,
  output logic [AW-1:0]     raddr_b_o,
  input  logic [WORD_W-1:0] rdata_a_i,
  input  logic [WORD_W-1:0] rdata_b_i,
  output logic [SMP_W-1:0]  sample_o,
  output logic              stb_o
);
  logic [AW-1:0]    cnt;
  logic [1:0]       ph;
  logic [SMP_W-1:0] cur;

  always_comb begin
    if (ilv_i) begin
      raddr_a_o = {cnt[AW-2:0], 1'b0};
      raddr_b_o = {cnt[AW-2:0], 1'b1};
      case (ph)
        2'd0:    cur = rdata_a_i[SMP_W-1:0];
        2'd1:    cur = rdata_b_i[SMP_W-1:0];
        default: cur = {rdata_a_i[WORD_W-1:SMP_W], rdata_b_i[WORD_W-1:SMP_W]};
      endcase
    end else begin
      raddr_a_o = cnt;
      raddr_b_o = cnt;
      cur       = rdata_a_i[SMP_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt      <= '0;
      ph       <= '0;
      sample_o <= MID;
      stb_o    <= 1'b0;
    end else if (!run_i) begin
      cnt      <= '0;
      ph       <= '0;
      sample_o <= MID;
      stb_o    <= 1'b0;
    end else begin
      stb_o <= tick_i;
      if (tick_i) begin
        sample_o <= cur;
        if (!ilv_i) begin
          cnt <= (cnt == AW'(DEPTH - 1)) ? '0 : cnt + AW'(1);
        end else if (ph == 2'd2) begin
          ph  <= '0;
          cnt <= (cnt[AW-2:0] == (AW-1)'(GRP - 1)) ? '0 : cnt + AW'(1);
        end else begin
          ph <= ph + 2'd1;
        end
      end
    end
  end

  // R5
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph != 2'd3);
  // R6
  park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt == '0 && ph == '0 && !stb_o));
endmodule

// File: rtl/cal_wave_player.sv
module cal_wave_player
  import cal_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int WORD_W  = 18,
  parameter int DEPTH   = 256,
  parameter int PRESC_W = 4,
  parameter int DIV_W   = 8,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [SMP_W-1:0]  func_sample_i,
  output logic [SMP_W-1:0]  dac_o,
  output logic              sample_stb_o
);
  logic               en, rld, ilv, run, tick, mem_we;
  logic [PRESC_W-1:0] presc;
  logic [DIV_W-1:0]   div;
  logic [AW-1:0]      mem_waddr, raddr_a, raddr_b;
  logic [WORD_W-1:0]  mem_wdata, rdata_a, rdata_b;
  logic [SMP_W-1:0]   play_sample;

  cal_cfg_regs #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PRESC_W(PRESC_W), .DIV_W(DIV_W)) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en), .rld_o(rld), .ilv_o(ilv), .presc_o(presc), .div_o(div),
    .mem_we_o(mem_we), .mem_addr_o(mem_waddr), .mem_wdata_o(mem_wdata)
  );

  assign run = en && !rld;

  cal_tick_gen #(.PRESC_W(PRESC_W), .DIV_W(DIV_W)) tick_i (
    .clk_i, .rst_ni, .run_i(run), .presc_i(presc), .div_i(div), .tick_o(tick)
  );

  cal_sample_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) mem_i (
    .clk_i, .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_a_i(raddr_a), .raddr_b_i(raddr_b), .rdata_a_o(rdata_a), .rdata_b_o(rdata_b)
  );

  cal_play_seq #(.SMP_W(SMP_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) seq_i (
    .clk_i, .rst_ni, .run_i(run), .tick_i(tick), .ilv_i(ilv),
    .raddr_a_o(raddr_a), .raddr_b_o(raddr_b), .rdata_a_i(rdata_a), .rdata_b_i(rdata_b),
    .sample_o(play_sample), .stb_o(sample_stb_o)
  );

  assign dac_o = en ? play_sample : func_sample_i;

  // R6
  no_stb_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rld) && rld) |-> !sample_stb_o);
endmodule

// File: tb/cal_wave_player_tb_top.sv
`timescale 1ns/1ps
module cal_wave_player_tb_top;
  localparam int A_CTRL = 0, A_PRESC = 1, A_DIV = 2, A_PTR = 3, A_DATA = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic [11:0] func_smp = 12'h5a5;
  logic [11:0] dac;
  logic        stb;

  cal_wave_player dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .func_sample_i(func_smp), .dac_o(dac), .sample_stb_o(stb)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, ns = 0;
  int st_t[2048];
  logic [11:0] st_v[2048];
  logic [17:0] model[256];

  always @(posedge clk) cyc++;
  always @(negedge clk) if (rst_n && stb && ns < 2048) begin
    st_t[ns] = cyc; st_v[ns] = dac; ns++;
  end

  function automatic logic [11:0] exp_smp(bit ilv, int k);
    int s, g, p;
    if (!ilv) return model[k % 256][11:0];
    s = k % 384; g = s / 3; p = s % 3;
    if (p == 0) return model[2*g][11:0];
    if (p == 1) return model[2*g+1][11:0];
    return {model[2*g][17:12], model[2*g+1][17:12]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 18'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctrl(bit en, bit ilv, bit rld);
    wr(A_CTRL, (int'(rld) << 4) | (int'(ilv) << 5) | (int'(en) << 6));
  endtask

  task automatic stop_play();
    ctrl(1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
  endtask

  task automatic start_play(bit ilv, int n);
    ns = 0;
    ctrl(1'b1, ilv, 1'b0);
    wait (ns >= n);
    stop_play();
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1
    chk(dac == func_smp, "R1 dac in reset", dac, func_smp);
    chk(stb == 1'b0, "R1 stb in reset", stb, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dac == func_smp && !stb, "R1 dac after reset", dac, func_smp);

    // R2 functional path while disabled
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      func_smp = 12'($urandom);
      #1;
      chk(dac == func_smp, "R2 bypass", dac, func_smp);
    end

    // R7 load memory
    wr(A_PTR, 0);
    for (int k = 0; k < 256; k++) begin
      model[k] = 18'($urandom);
      wr(A_DATA, model[k]);
    end

    // R4 normal playback with wrap, R3 period 2
    wr(A_PRESC, 0); wr(A_DIV, 1);
    start_play(1'b0, 300);
    for (int k = 0; k < 300; k++)
      chk(st_v[k] == exp_smp(1'b0, k), "R4 normal sample", st_v[k], exp_smp(1'b0, k));
    chk(st_t[1] - st_t[0] == 2, "R3 period p0 d1", st_t[1] - st_t[0], 2);

    // R3 period sweep
    for (int i = 0; i < 7; i++) begin
      int p, d, per;
      case (i)
        0: begin p = 0; d = 0; end
        1: begin p = 1; d = 2; end
        2: begin p = 2; d = 1; end
        3: begin p = 3; d = 0; end
        default: begin p = $urandom % 4; d = $urandom % 8; end
      endcase
      per = (1 << p) * (d + 1);
      wr(A_PRESC, p); wr(A_DIV, d);
      start_play(1'b0, 4);
      chk(st_t[1] - st_t[0] == per, "R3 period a", st_t[1] - st_t[0], per);
      chk(st_t[3] - st_t[2] == per, "R3 period b", st_t[3] - st_t[2], per);
      chk(st_v[0] == exp_smp(1'b0, 0), "R6 restart at 0", st_v[0], exp_smp(1'b0, 0));
    end

    // R5 packed playback with wrap
    wr(A_PRESC, 0); wr(A_DIV, 0);
    start_play(1'b1, 400);
    for (int k = 0; k < 400; k++)
      chk(st_v[k] == exp_smp(1'b1, k), "R5 packed sample", st_v[k], exp_smp(1'b1, k));

    // R6 reload parks the player
    ns = 0;
    ctrl(1'b1, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    chk(ns == 0, "R6 no strobe while reload", ns, 0);
    chk(dac == 12'd2048, "R6 mid-scale while reload", dac, 2048);
    start_play(1'b0, 20);
    chk(st_v[0] == exp_smp(1'b0, 0), "R6 first sample", st_v[0], exp_smp(1'b0, 0));
    start_play(1'b0, 3);
    chk(st_v[0] == exp_smp(1'b0, 0) && st_v[1] == exp_smp(1'b0, 1),
        "R6 resume at 0", st_v[1], exp_smp(1'b0, 1));

    // R7 pointer set and wrap
    wr(A_PTR, 5);
    for (int k = 5; k < 8; k++) begin model[k] = 18'($urandom); wr(A_DATA, model[k]); end
    wr(A_PTR, 255);
    model[255] = 18'($urandom); wr(A_DATA, model[255]);
    model[0] = 18'($urandom);   wr(A_DATA, model[0]);
    start_play(1'b0, 260);
    foreach (st_v[k]) if (k < 260 && (k == 0 || (k >= 5 && k <= 8) || k >= 255))
      chk(st_v[k] == exp_smp(1'b0, k), "R7 pointer data", st_v[k], exp_smp(1'b0, k));

    // R8 divisor change mid-interval
    wr(A_PRESC, 0); wr(A_DIV, 3);
    ns = 0;
    ctrl(1'b1, 1'b0, 1'b0);
    wait (ns >= 3);
    wr(A_DIV, 9);
    wait (ns >= 7);
    stop_play();
    chk(st_t[3] - st_t[2] == 4, "R8 old period kept", st_t[3] - st_t[2], 4);
    chk(st_t[4] - st_t[3] == 10, "R8 new period", st_t[4] - st_t[3], 10);
    chk(st_t[5] - st_t[4] == 10, "R8 new period steady", st_t[5] - st_t[4], 10);

    // R2 disabled after runs
    func_smp = 12'h123; #1;
    chk(dac == 12'h123, "R2 bypass after stop", dac, 12'h123);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule